// File: doc/BRIEF.md
# Cache Miss Line-Fill Controller

This block sits between the tag lookup of a small cache and a simple external bus. Each cycle it receives a lookup: the access address, whether it is an instruction or a data access, whether it is cacheable, and whether the tag array already hit. The block also holds a one-line fill buffer, which keeps the last line it fetched. When a cacheable access misses both the tag array and that buffer, and the cache is enabled, the block issues an external fetch.

A fetch is either a full 16-byte line of four 32-bit words or a single word. Data misses always fetch a line. For instruction misses the size depends on a 2-bit fill-mode field and on address bits [3:2]. A line is fetched as four request/acknowledge beats. The first beat is the word that missed, and the offset then wraps modulo 16. The stalled requester is released when that first word arrives. The fill buffer becomes valid only after all four beats have arrived.

A small control register holds an enable bit and the fill-mode field. Writing a 1 to its invalidate bit sends a one-cycle invalidate-all pulse to the tag array and also clears the fill buffer.

Top module: `linefill_ctrl`

## Requirements
- R1: After reset the control register reads 0, so the cache is disabled. `bus_req`, `tag_inval_all`, `fb_hit` and `miss_done` are all low.
- R2: The block raises `bus_req` in the cycle after a lookup only when all of these hold: the enable bit (bit 31) is 1, the access is cacheable, `acc_tag_hit` is 0, and the fill buffer misses. In every other case no fetch starts.
- R3: A data miss (`acc_instr`=0) always fetches a line, shown by `bus_line`=1 and four beats.
- R4: For an instruction miss with fill mode (control bits [17:16]) 00, the block fetches a line when address[3:2] is 00, 01 or 10. When address[3:2] is 11 it fetches a single word, shown by `bus_line`=0 and one beat.
- R5: For an instruction miss with fill mode 01, the block fetches a line when address[3:2] is 00 or 01, and a single word when it is 10 or 11.
- R6: With fill mode 10 or 11, every instruction miss fetches a line.
- R7: `bus_addr` is {line address[31:4], offset, 2'b00}. The first offset is the miss address[3:2], and each acknowledged beat adds 1 modulo 4. While `bus_ack` is low, the request and its address hold.
- R8: `miss_done` is high only in the cycle in which the first beat of a fetch is acknowledged, and only once per fetch.
- R9: Once all four beats of a line have arrived, a cacheable lookup of that line with the cache enabled gives `fb_hit`=1. In that case `fb_rdata` is the word at address[3:2], and no fetch starts. A single-word fetch leaves the fill buffer unchanged.
- R10: A control write with bit 24 set gives `tag_inval_all`=1 for exactly the next cycle and clears the fill buffer. Bit 24 reads back as 0, and the enable bit and fill mode take the written values.
- R11: If an invalidate pulse falls in any cycle of a line fill, the fill still completes on the bus, but the fill buffer stays invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 32 | Control write data: bit 31 enable, bit 24 invalidate, bits 17:16 fill mode |
| ctl_rd_data | output | 32 | Control register readback |
| tag_inval_all | output | 1 | One-cycle pulse that invalidates all tag entries |
| acc_valid | input | 1 | Lookup present this cycle |
| acc_addr | input | 32 | Lookup byte address |
| acc_instr | input | 1 | 1 for an instruction fetch, 0 for a data access |
| acc_cacheable | input | 1 | Access is cacheable |
| acc_tag_hit | input | 1 | The tag array hit for this lookup |
| fb_hit | output | 1 | The lookup hits the fill buffer |
| fb_rdata | output | 32 | Fill-buffer word selected by address[3:2] |
| miss_done | output | 1 | The first word has arrived; releases the requester |
| bus_req | output | 1 | External beat request |
| bus_line | output | 1 | 1 for a four-beat line fetch, 0 for a single word |
| bus_addr | output | 32 | Beat word address |
| bus_ack | input | 1 | Beat acknowledge; `bus_rdata` is valid |
| bus_rdata | input | 32 | Beat read data |

## Verification
Two events can coincide: an invalidate pulse and a line fill that is in progress. The worst case is a pulse in the same cycle as the final beat, which would otherwise set the buffer valid. The bench provokes this by writing the invalidate bit during a chosen beat, including the last one, with randomly placed acknowledge delays around it. It then judges the outcome at the ports: the next lookup of the same line must miss the buffer and start a new fetch. The bench also repeats accesses to lines that have just been filled, so that buffer hits, single-word fetches and the wrap order are checked against each other.

// File: rtl/lf_pkg.sv
package lf_pkg;
    localparam int LF_REG_W    = 32;
    localparam int LF_WORDS    = 4;
    localparam int LF_OFF_W    = $clog2(LF_WORDS);
    localparam int LF_LINE_LSB = LF_OFF_W + 2;
    localparam int LF_EN_BIT   = 31;
    localparam int LF_INV_BIT  = 24;
    localparam int LF_MODE_LO  = 16;

    typedef struct packed {
        logic       en;
        logic [1:0] mode;
        logic       inval;
    } lf_ctl_t;

    // 1: fetch a whole line, 0: fetch one word
    function automatic logic lf_line_fetch(logic is_instr, logic [1:0] mode,
                                           logic [LF_OFF_W-1:0] off);
        if (!is_instr) return 1'b1;
        unique case (mode)
            2'b00:   return (off != 2'b11);
            2'b01:   return !off[1];
            default: return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/lf_ctl_reg.sv
module lf_ctl_reg
    import lf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [LF_REG_W-1:0] wr_data,
    output lf_ctl_t             ctl,
    output logic [LF_REG_W-1:0] rd_data
);
    lf_ctl_t c_d, c_q;
    logic    unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    always_comb begin
        c_d       = c_q;
        c_d.inval = 1'b0;
        if (wr_en) begin
            c_d.en    = wr_data[LF_EN_BIT];
            c_d.mode  = wr_data[LF_MODE_LO +: 2];
            c_d.inval = wr_data[LF_INV_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        rd_data                   = '0;
        rd_data[LF_EN_BIT]        = c_q.en;
        rd_data[LF_MODE_LO +: 2]  = c_q.mode;
    end

    assign ctl = c_q;
endmodule

// File: rtl/lf_size_dec.sv
module lf_size_dec
    import lf_pkg::*;
(
    input  logic                is_instr,
    input  logic [1:0]          mode,
    input  logic [LF_OFF_W-1:0] off,
    output logic                line,
    output logic [LF_OFF_W-1:0] beats_m1
);
    always_comb begin
        line     = lf_line_fetch(is_instr, mode, off);
        beats_m1 = line ? LF_OFF_W'(LF_WORDS - 1) : '0;
    end
endmodule

// File: rtl/lf_fill_buf.sv
module lf_fill_buf
    import lf_pkg::*;
#(
    parameter int TAG_W  = 28,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [TAG_W-1:0]    load_tag,
    input  logic                wr_en,
    input  logic [LF_OFF_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                set_valid,
    input  logic                clr_valid,
    input  logic [TAG_W-1:0]    lk_tag,
    input  logic [LF_OFF_W-1:0] lk_idx,
    output logic                hit,
    output logic [DATA_W-1:0]   rdata
);
    typedef struct packed {
        logic                             valid;
        logic [TAG_W-1:0]                 tag;
        logic [LF_WORDS-1:0][DATA_W-1:0]  words;
    } fb_t;

    fb_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (load) begin
            b_d.valid = 1'b0;
            b_d.tag   = load_tag;
        end
        if (wr_en)     b_d.words[wr_idx] = wr_data;
        if (set_valid) b_d.valid = 1'b1;
        if (clr_valid) b_d.valid = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign hit   = b_q.valid && (b_q.tag == lk_tag);
    assign rdata = b_q.words[lk_idx];
endmodule

// File: rtl/linefill_ctrl.sv
module linefill_ctrl
    import lf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_en,
    input  logic [31:0]       ctl_wr_data,
    output logic [31:0]       ctl_rd_data,
    output logic              tag_inval_all,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_instr,
    input  logic              acc_cacheable,
    input  logic              acc_tag_hit,
    output logic              fb_hit,
    output logic [DATA_W-1:0] fb_rdata,
    output logic              miss_done,
    output logic              bus_req,
    output logic              bus_line,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int TAG_W = ADDR_W - LF_LINE_LSB;

    typedef struct packed {
        logic                busy;
        logic                line;
        logic                first;
        logic                kill;
        logic [TAG_W-1:0]    tag;
        logic [LF_OFF_W-1:0] off;
        logic [LF_OFF_W-1:0] left;
    } fsm_t;

    fsm_t                s_d, s_q;
    lf_ctl_t             ctl;
    logic                buf_hit;
    logic                dec_line;
    logic [LF_OFF_W-1:0] dec_left;
    logic                start, beat, last;
    logic [TAG_W-1:0]    acc_tag;
    logic [LF_OFF_W-1:0] acc_off;
    logic                unused_addr_lsb;

    assign acc_tag         = acc_addr[ADDR_W-1:LF_LINE_LSB];
    assign acc_off         = acc_addr[LF_LINE_LSB-1:2];
    assign unused_addr_lsb = ^acc_addr[1:0];

    lf_ctl_reg u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr_en),
        .wr_data (ctl_wr_data),
        .ctl     (ctl),
        .rd_data (ctl_rd_data)
    );

    lf_size_dec u_dec (
        .is_instr (acc_instr),
        .mode     (ctl.mode),
        .off      (acc_off),
        .line     (dec_line),
        .beats_m1 (dec_left)
    );

    always_comb begin
        start = !s_q.busy && ctl.en && acc_valid && acc_cacheable
                && !acc_tag_hit && !buf_hit;
        beat  = s_q.busy && bus_ack;
        last  = beat && (s_q.left == '0);
    end

    lf_fill_buf #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_fb (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start && dec_line),
        .load_tag  (acc_tag),
        .wr_en     (beat && s_q.line),
        .wr_idx    (s_q.off),
        .wr_data   (bus_rdata),
        .set_valid (last && s_q.line && !s_q.kill),
        .clr_valid (ctl.inval),
        .lk_tag    (acc_tag),
        .lk_idx    (acc_off),
        .hit       (buf_hit),
        .rdata     (fb_rdata)
    );

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.busy  = 1'b1;
            s_d.line  = dec_line;
            s_d.first = 1'b1;
            s_d.kill  = 1'b0;
            s_d.tag   = acc_tag;
            s_d.off   = acc_off;
            s_d.left  = dec_left;
        end
        if (beat) begin
            s_d.first = 1'b0;
            s_d.off   = s_q.off + 1'b1;
            s_d.left  = s_q.left - 1'b1;
            if (last) s_d.busy = 1'b0;
        end
        if (ctl.inval && s_q.busy && s_q.line) s_d.kill = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fb_hit        = ctl.en && acc_valid && acc_cacheable && buf_hit;
    assign miss_done     = beat && s_q.first;
    assign bus_req       = s_q.busy;
    assign bus_line      = s_q.line;
    assign bus_addr      = {s_q.tag, s_q.off, 2'b00};
    assign tag_inval_all = ctl.inval;
endmodule

// File: rtl/lf_checker.sv
module lf_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       ctl_rd_data,
    input logic              tag_inval_all,
    input logic              fb_hit,
    input logic              miss_done,
    input logic              bus_req,
    input logic              bus_line,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ack
);
    // R2: a fetch starts only if the cache was enabled in the lookup cycle
    p_fetch_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(ctl_rd_data[31]));

    // R4: a single-word fetch ends after its one beat
    p_single_one_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && !bus_line) |=> !bus_req);

    // R7: the request and its address hold while they wait for an acknowledge
    p_hold_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));

    // R7: the offset advances modulo four within the same line
    p_wrap_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> (!bus_req ||
            ((bus_addr[3:2] == $past(bus_addr[3:2]) + 2'd1) &&
             (bus_addr[ADDR_W-1:4] == $past(bus_addr[ADDR_W-1:4])))));

    // R8: release only with an acknowledged beat, and never twice in a row
    p_done_on_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        miss_done |-> (bus_req && bus_ack));
    p_done_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        miss_done |=> !miss_done);

    // R9: a buffer hit while idle starts no fetch
    p_hit_no_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_hit && !bus_req) |=> !bus_req);

    // R10: the invalidate pulse lasts one cycle
    p_inval_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tag_inval_all |=> !tag_inval_all);
endmodule

bind linefill_ctrl lf_checker #(.ADDR_W(ADDR_W)) u_lf_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_rd_data   (ctl_rd_data),
    .tag_inval_all (tag_inval_all),
    .fb_hit        (fb_hit),
    .miss_done     (miss_done),
    .bus_req       (bus_req),
    .bus_line      (bus_line),
    .bus_addr      (bus_addr),
    .bus_ack       (bus_ack)
);

// File: tb/linefill_ctrl_tb.sv
module linefill_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [31:0] ctl_wr_data = '0;
    logic [31:0] ctl_rd_data;
    logic        tag_inval_all;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_instr = 1'b0;
    logic        acc_cacheable = 1'b0;
    logic        acc_tag_hit = 1'b0;
    logic        fb_hit;
    logic [31:0] fb_rdata;
    logic        miss_done;
    logic        bus_req;
    logic        bus_line;
    logic [31:0] bus_addr;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model
    logic        m_en = 1'b0;
    logic [1:0]  m_mode = 2'b00;
    logic        m_fbv = 1'b0;
    logic [27:0] m_tag = '0;
    logic [31:0] m_w [4];

    always #10 clk = ~clk;

    linefill_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
        .tag_inval_all(tag_inval_all),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_instr(acc_instr),
        .acc_cacheable(acc_cacheable), .acc_tag_hit(acc_tag_hit),
        .fb_hit(fb_hit), .fb_rdata(fb_rdata), .miss_done(miss_done),
        .bus_req(bus_req), .bus_line(bus_line), .bus_addr(bus_addr),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_line(input logic instr, input logic [1:0] mode,
                                      input logic [1:0] off);
        if (!instr)           return 1'b1;
        if (mode == 2'b00)    return off != 2'd3;
        if (mode == 2'b01)    return off < 2'd2;
        return 1'b1;
    endfunction

    function automatic string size_req(input logic instr, input logic [1:0] mode);
        if (!instr)        return "R3";
        if (mode == 2'b00) return "R4";
        if (mode == 2'b01) return "R5";
        return "R6";
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'd2654435761) ^ 32'h3C5A_0F96;
    endfunction

    function automatic logic [31:0] ctl_word(input logic en, input logic [1:0] mode,
                                             input logic inv);
        logic [31:0] w = '0;
        w[31] = en; w[24] = inv; w[17:16] = mode;
        return w;
    endfunction

    // called at a negedge; returns at a negedge
    task automatic ctl_write(input logic en, input logic [1:0] mode, input logic inv);
        ctl_wr_en = 1'b1; ctl_wr_data = ctl_word(en, mode, inv);
        @(posedge clk); @(negedge clk);
        ctl_wr_en = 1'b0;
        m_en = en; m_mode = mode;
        check(ctl_rd_data == ctl_word(en, mode, 1'b0), "R10", ctl_rd_data,
              ctl_word(en, mode, 1'b0));
        check(tag_inval_all == inv, "R10", 32'(tag_inval_all), 32'(inv));
        @(posedge clk); @(negedge clk);
        check(tag_inval_all == 1'b0, "R10", 32'(tag_inval_all), 0);
        if (inv) m_fbv = 1'b0;
    endtask

    // inval_beat: beat index at which an invalidate write is issued (-1 none)
    task automatic access(input logic [31:0] a, input logic instr, input logic cach,
                          input logic thit, input int inval_beat);
        logic       e_hit, e_fetch, e_line, kill;
        logic [1:0] off;
        int         beats;
        a[1:0] = 2'b00;
        e_hit   = m_en && cach && m_fbv && (m_tag == a[31:4]);
        e_fetch = m_en && cach && !thit && !e_hit;
        e_line  = exp_line(instr, m_mode, a[3:2]);
        acc_valid = 1'b1; acc_addr = a; acc_instr = instr;
        acc_cacheable = cach; acc_tag_hit = thit;
        #1;
        check(fb_hit == e_hit, "R9", 32'(fb_hit), 32'(e_hit));
        if (e_hit) check(fb_rdata == m_w[a[3:2]], "R9", fb_rdata, m_w[a[3:2]]);
        @(posedge clk); @(negedge clk);
        acc_valid = 1'b0;
        check(bus_req == e_fetch, "R2", 32'(bus_req), 32'(e_fetch));
        if (!(e_fetch && bus_req)) return;
        check(bus_line == e_line, size_req(instr, m_mode), 32'(bus_line), 32'(e_line));
        beats = e_line ? 4 : 1;
        kill  = 1'b0;
        if (e_line) m_fbv = 1'b0;
        off = a[3:2];
        for (int i = 0; i < beats; i++) begin
            int d = $urandom_range(0, 2);
            logic [31:0] ea = {a[31:4], off, 2'b00};
            for (int k = 0; k < d; k++) begin
                check(bus_req && bus_addr == ea, "R7", bus_addr, ea);
                @(posedge clk); @(negedge clk);
            end
            check(bus_req == 1'b1, "R7", 32'(bus_req), 1);
            check(bus_addr == ea, "R7", bus_addr, ea);
            bus_ack = 1'b1; bus_rdata = mem_word(ea);
            if (i == inval_beat) begin
                ctl_wr_en = 1'b1; ctl_wr_data = ctl_word(m_en, m_mode, 1'b1);
                kill = 1'b1;
            end
            #1;
            check(miss_done == (i == 0), "R8", 32'(miss_done), 32'(i == 0));
            if (e_line) m_w[off] = mem_word(ea);
            off = off + 2'd1;
            @(posedge clk); @(negedge clk);
            bus_ack = 1'b0; ctl_wr_en = 1'b0;
        end
        check(bus_req == 1'b0, beats == 1 ? "R4" : "R3", 32'(bus_req), 0);
        if (kill && inval_beat == beats - 1) begin
            check(tag_inval_all == 1'b1, "R11", 32'(tag_inval_all), 1);
        end
        if (e_line && !kill) begin
            m_fbv = 1'b1; m_tag = a[31:4];
        end
        if (kill) begin
            @(posedge clk); @(negedge clk);
            m_fbv = 1'b0;
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) m_w[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ctl_rd_data == 32'd0, "R1", ctl_rd_data, 0);
        check(!bus_req && !tag_inval_all && !miss_done, "R1",
              {29'd0, bus_req, tag_inval_all, miss_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!fb_hit && !bus_req, "R1", {30'd0, fb_hit, bus_req}, 0);
        // R2: disabled cache never fetches
        access(32'h0000_1000, 1'b0, 1'b1, 1'b0, -1);
        ctl_write(1'b1, 2'b00, 1'b1);
        // R3 + R7: data miss at offset 2 wraps 8,C,0,4
        access(32'h0000_2008, 1'b0, 1'b1, 1'b0, -1);
        // R9: hit every word of the filled line
        for (int k = 0; k < 4; k++) access(32'h0000_2000 + 32'(k * 4), 1'b1, 1'b1, 1'b0, -1);
        // R2: non-cacheable and tag hit start nothing
        access(32'h0000_3000, 1'b0, 1'b0, 1'b0, -1);
        access(32'h0000_3000, 1'b0, 1'b1, 1'b1, -1);
        // R4: mode 00 sweep of offsets; single word leaves buffer alone
        for (int k = 0; k < 4; k++) access(32'h0000_4000 + 32'(k * 16 * 4 + k * 4),
                                           1'b1, 1'b1, 1'b0, -1);
        access(32'h0000_4034, 1'b1, 1'b1, 1'b0, -1);
        // R5: mode 01 sweep
        ctl_write(1'b1, 2'b01, 1'b0);
        for (int k = 0; k < 4; k++) access(32'h0000_5000 + 32'(k * 16 * 4 + k * 4),
                                           1'b1, 1'b1, 1'b0, -1);
        // R6: modes 10 and 11
        ctl_write(1'b1, 2'b10, 1'b0);
        access(32'h0000_600C, 1'b1, 1'b1, 1'b0, -1);
        ctl_write(1'b1, 2'b11, 1'b0);
        access(32'h0000_610C, 1'b1, 1'b1, 1'b0, -1);
        access(32'h0000_6104, 1'b1, 1'b1, 1'b0, -1);
        // R10: invalidate drops the buffer; the same line fetches again
        ctl_write(1'b1, 2'b11, 1'b1);
        access(32'h0000_6108, 1'b0, 1'b1, 1'b0, -1);
        // R11: invalidate in mid fill and on the last beat
        access(32'h0000_7004, 1'b0, 1'b1, 1'b0, 1);
        access(32'h0000_7004, 1'b0, 1'b1, 1'b0, -1);
        access(32'h0000_8000, 1'b0, 1'b1, 1'b0, 3);
        access(32'h0000_8000, 1'b0, 1'b1, 1'b0, -1);
        // constrained random mix
        for (int n = 0; n < 300; n++) begin
            int r = $urandom_range(0, 19);
            if (r == 0) begin
                ctl_write(1'($urandom_range(0, 7) != 0), 2'($urandom_range(0, 3)),
                          1'($urandom_range(0, 1)));
            end else begin
                logic [31:0] a = {20'h00009, 6'($urandom_range(0, 3)), 6'($urandom_range(0, 15)) << 2};
                access(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) != 0),
                       1'($urandom_range(0, 5) == 0),
                       ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 3)) : -1);
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule